// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory access and write-back. It receives the register numbers, write enables and load flags held in the pipeline registers, and compares them. From those comparisons it decides where each execute-stage operand comes from, when the front of the pipeline must wait, and when the instruction fetched behind a taken branch must be discarded. The datapath muxes, the register file and the branch comparator are outside the block. The block only drives their controls.

Branches are resolved in decode, so a taken branch costs one fetch slot. That slot is cleared by a squash output. A decode-stage branch reads its operands one stage earlier than an ALU instruction does. It therefore waits while its source is still being produced in execute, or while a load is still in the memory stage. It takes an ALU result from the memory stage through a separate decode bypass. An instruction that uses the result of the load directly in front of it waits one cycle. During that cycle the program counter and the fetch/decode register hold their values, and a bubble with every write enable cleared enters execute. The register file writes in the first half of the cycle, so a write-back result reaches decode without any select.

The block is purely combinational: every output is a function of the present inputs.

Top module: `hazard_unit`

## Requirements
- R1: An execute operand whose register number equals the memory-stage destination selects the memory-stage value (select code 2'b10), provided that the memory stage writes a register other than 0.
- R2: An execute operand whose register number equals the write-back destination selects the write-back value (code 2'b01), provided that write-back writes a register other than 0 and the memory stage does not match. When no stage matches, the select is 2'b00 (register file). The first operand uses fwd_a_sel_o with ex_rs_i, and the second uses fwd_b_sel_o with ex_rt_i.
- R3: When the memory stage and the write-back stage both match an operand, the memory-stage value wins (2'b10).
- R4: A producer whose destination is register 0, or whose write enable is low, never causes a bypass, a stall or a decode forward.
- R5: When execute holds a load whose destination matches a decode source that is in use, pc_hold_o, ifid_hold_o and idex_bubble_o are all 1 for that cycle.
- R6: A decode source whose use flag is low causes no load-use stall.
- R7: A branch in decode whose rs or rt matches a writing execute-stage destination stalls, whether that producer is a load or an ALU instruction.
- R8: A branch in decode whose source matches a memory-stage load stalls. If the memory-stage producer is not a load, the branch does not stall and the matching id_fwd_a_o (rs) or id_fwd_b_o (rt) is 1.
- R9: ifid_flush_o is 1 only when a branch in decode is taken and no stall is raised in that cycle.
- R10: A source that matches only the write-back destination produces no decode forward and no stall, because the register file returns the value written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | AW | decode first source register |
| id_rt_i | input | AW | decode second source register |
| id_rs_use_i | input | 1 | decode reads first source |
| id_rt_use_i | input | 1 | decode reads second source |
| id_branch_i | input | 1 | decode holds a conditional branch |
| id_br_taken_i | input | 1 | decode branch compare result is taken |
| ex_rs_i | input | AW | execute first source register |
| ex_rt_i | input | AW | execute second source register |
| ex_rd_i | input | AW | execute destination register |
| ex_we_i | input | 1 | execute instruction writes a register |
| ex_load_i | input | 1 | execute instruction is a load |
| mem_rd_i | input | AW | memory-stage destination register |
| mem_we_i | input | 1 | memory-stage instruction writes a register |
| mem_load_i | input | 1 | memory-stage instruction is a load |
| wb_rd_i | input | AW | write-back destination register |
| wb_we_i | input | 1 | write-back writes a register |
| fwd_a_sel_o | output | 2 | execute first operand source select |
| fwd_b_sel_o | output | 2 | execute second operand source select |
| id_fwd_a_o | output | 1 | branch first operand taken from memory stage |
| id_fwd_b_o | output | 1 | branch second operand taken from memory stage |
| pc_hold_o | output | 1 | keep program counter |
| ifid_hold_o | output | 1 | keep fetch/decode register |
| idex_bubble_o | output | 1 | load a no-op into execute |
| ifid_flush_o | output | 1 | squash the fetched instruction |

## Verification
The assertions assume that the inputs describe a consistent pipeline. A memory-stage destination never feeds an execute operand while the memory stage holds a load, because the load-use stall keeps that pairing from forming. The branch-taken flag is also only meaningful while a branch sits in decode. Every directed scenario in the bench builds a pipeline snapshot that could really occur under these rules. In particular, no scenario pairs a memory-stage load with a matching execute operand.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_REG = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/hu_operand_fwd.sv
module hu_operand_fwd
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output src_sel_e      sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i && (wb_rd_i != '0) && (wb_rd_i == src_i);

  // younger producer wins
  always_comb begin
    if (mem_hit)     sel_o = SRC_MEM;
    else if (wb_hit) sel_o = SRC_WB;
    else             sel_o = SRC_REG;
  end
endmodule

// File: rtl/hu_load_use.sv
module hu_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_rs_use_i,
  input  logic          id_rt_use_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  output logic          stall_o
);
  logic live;

  assign live    = ex_load_i && ex_we_i && (ex_rd_i != '0);
  assign stall_o = live && ((id_rs_use_i && (id_rs_i == ex_rd_i)) ||
                            (id_rt_use_i && (id_rt_i == ex_rd_i)));
endmodule

// File: rtl/hu_branch_ctl.sv
module hu_branch_ctl #(
  parameter int AW = 5
) (
  input  logic          id_branch_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  output logic          stall_o,
  output logic          fwd_rs_o,
  output logic          fwd_rt_o
);
  localparam int NSRC = 2;

  logic [AW-1:0] src [NSRC];
  logic [NSRC-1:0] ex_hit, mem_hit;
  logic ex_live, mem_live;

  assign src[0]   = id_rs_i;
  assign src[1]   = id_rt_i;
  assign ex_live  = id_branch_i && ex_we_i && (ex_rd_i != '0);
  assign mem_live = id_branch_i && mem_we_i && (mem_rd_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign ex_hit[g]  = ex_live && (src[g] == ex_rd_i);
    assign mem_hit[g] = mem_live && (src[g] == mem_rd_i);
  end

  // value still in flight: wait; ALU result in memory stage: bypass
  assign stall_o  = (|ex_hit) || (mem_load_i && (|mem_hit));
  assign fwd_rs_o = mem_hit[0] && !mem_load_i && !ex_hit[0];
  assign fwd_rt_o = mem_hit[1] && !mem_load_i && !ex_hit[1];
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_rs_use_i,
  input  logic          id_rt_use_i,
  input  logic          id_branch_i,
  input  logic          id_br_taken_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_sel_o,
  output logic [1:0]    fwd_b_sel_o,
  output logic          id_fwd_a_o,
  output logic          id_fwd_b_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          idex_bubble_o,
  output logic          ifid_flush_o
);
  localparam int NOPS = 2;

  logic [AW-1:0] ex_src [NOPS];
  src_sel_e      sel    [NOPS];
  logic          lu_stall, br_stall, stall;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hu_operand_fwd #(.AW(AW)) u_fwd (
      .src_i   (ex_src[g]),
      .mem_rd_i(mem_rd_i),
      .mem_we_i(mem_we_i),
      .wb_rd_i (wb_rd_i),
      .wb_we_i (wb_we_i),
      .sel_o   (sel[g])
    );
  end

  hu_load_use #(.AW(AW)) u_lu (
    .id_rs_i    (id_rs_i),
    .id_rt_i    (id_rt_i),
    .id_rs_use_i(id_rs_use_i),
    .id_rt_use_i(id_rt_use_i),
    .ex_rd_i    (ex_rd_i),
    .ex_we_i    (ex_we_i),
    .ex_load_i  (ex_load_i),
    .stall_o    (lu_stall)
  );

  hu_branch_ctl #(.AW(AW)) u_br (
    .id_branch_i(id_branch_i),
    .id_rs_i    (id_rs_i),
    .id_rt_i    (id_rt_i),
    .ex_rd_i    (ex_rd_i),
    .ex_we_i    (ex_we_i),
    .mem_rd_i   (mem_rd_i),
    .mem_we_i   (mem_we_i),
    .mem_load_i (mem_load_i),
    .stall_o    (br_stall),
    .fwd_rs_o   (id_fwd_a_o),
    .fwd_rt_o   (id_fwd_b_o)
  );

  assign stall         = lu_stall || br_stall;
  assign fwd_a_sel_o   = sel[0];
  assign fwd_b_sel_o   = sel[1];
  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;
  // compare result is unreliable while waiting on an operand
  assign ifid_flush_o  = id_branch_i && id_br_taken_i && !stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_rs_i,
  input logic [AW-1:0] id_rt_i,
  input logic          id_rs_use_i,
  input logic          id_rt_use_i,
  input logic          id_branch_i,
  input logic          id_br_taken_i,
  input logic [AW-1:0] ex_rs_i,
  input logic [AW-1:0] ex_rt_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic          mem_load_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_we_i,
  input logic [1:0]    fwd_a_sel_o,
  input logic [1:0]    fwd_b_sel_o,
  input logic          id_fwd_a_o,
  input logic          id_fwd_b_o,
  input logic          pc_hold_o,
  input logic          ifid_hold_o,
  input logic          idex_bubble_o,
  input logic          ifid_flush_o
);
  always_comb begin
    assert_mem_sel_src_R1: assert (fwd_a_sel_o != 2'b10 ||
      (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i));
    assert_wb_sel_src_R2: assert (fwd_b_sel_o != 2'b01 ||
      (wb_we_i && wb_rd_i != '0 && wb_rd_i == ex_rt_i));
    assert_mem_first_R3: assert (!(mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i) ||
      fwd_a_sel_o == 2'b10);
    assert_sel_code_R2: assert (fwd_a_sel_o != 2'b11 && fwd_b_sel_o != 2'b11);
    assert_zero_quiet_R4: assert (!(ex_rd_i == '0 && mem_rd_i == '0 && wb_rd_i == '0) ||
      (!pc_hold_o && fwd_a_sel_o == 2'b00 && fwd_b_sel_o == 2'b00 && !id_fwd_a_o && !id_fwd_b_o));
    assert_hold_set_R5: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == idex_bubble_o);
    assert_idfwd_alu_R8: assert (!(id_fwd_a_o || id_fwd_b_o) ||
      (mem_we_i && !mem_load_i && id_branch_i));
    assert_flush_R9: assert (!ifid_flush_o || (id_br_taken_i && !pc_hold_o));
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) chk_i (.*);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_rs_use, id_rt_use, id_branch, id_br_taken;
  logic ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic id_fwd_a, id_fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  hazard_unit #(.AW(AW)) dut_i (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_rs_use_i(id_rs_use), .id_rt_use_i(id_rt_use),
    .id_branch_i(id_branch), .id_br_taken_i(id_br_taken),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_sel_o(fwd_a), .fwd_b_sel_o(fwd_b), .id_fwd_a_o(id_fwd_a), .id_fwd_b_o(id_fwd_b),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .idex_bubble_o(idex_bubble),
    .ifid_flush_o(ifid_flush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    id_rs = '0; id_rt = '0; id_rs_use = 0; id_rt_use = 0; id_branch = 0; id_br_taken = 0;
    ex_rs = '0; ex_rt = '0; ex_rd = '0; ex_we = 0; ex_load = 0;
    mem_rd = '0; mem_we = 0; mem_load = 0; wb_rd = '0; wb_we = 0;
  endtask

  task automatic chk_stall(input string tag, input int exp);
    chk({tag, " pc_hold"}, pc_hold, exp);
    chk({tag, " ifid_hold"}, ifid_hold, exp);
    chk({tag, " idex_bubble"}, idex_bubble, exp);
  endtask

  task automatic t_reset_state();
    idle(); #1;
    chk("R2 idle fwd_a", fwd_a, 0);
    chk("R2 idle fwd_b", fwd_b, 0);
    chk_stall("R5 idle", 0);
    chk("R9 idle flush", ifid_flush, 0);
  endtask

  task automatic t_mem_fwd_r1();
    idle(); ex_rs = 5'd3; ex_rt = 5'd4; mem_rd = 5'd3; mem_we = 1; #1;
    chk("R1 mem->a", fwd_a, 2); chk("R1 b untouched", fwd_b, 0);
    idle(); ex_rs = 5'd9; ex_rt = 5'd12; mem_rd = 5'd12; mem_we = 1; #1;
    chk("R1 mem->b", fwd_b, 2); chk("R1 a untouched", fwd_a, 0);
  endtask

  task automatic t_wb_fwd_r2();
    idle(); ex_rs = 5'd7; ex_rt = 5'd7; wb_rd = 5'd7; wb_we = 1; mem_rd = 5'd8; mem_we = 1; #1;
    chk("R2 wb->a", fwd_a, 1); chk("R2 wb->b", fwd_b, 1);
  endtask

  task automatic t_priority_r3();
    idle(); ex_rs = 5'd5; ex_rt = 5'd31; mem_rd = 5'd5; mem_we = 1; wb_rd = 5'd5; wb_we = 1; #1;
    chk("R3 mem over wb", fwd_a, 2); chk("R3 other op", fwd_b, 0);
    idle(); ex_rt = 5'd31; mem_rd = 5'd31; mem_we = 1; wb_rd = 5'd31; wb_we = 1; #1;
    chk("R3 mem over wb b", fwd_b, 2);
  endtask

  task automatic t_zero_disabled_r4();
    idle(); ex_rs = 5'd0; mem_rd = 5'd0; mem_we = 1; wb_rd = 5'd0; wb_we = 1; #1;
    chk("R4 r0 no fwd", fwd_a, 0);
    idle(); ex_rs = 5'd6; ex_rt = 5'd6; mem_rd = 5'd6; mem_we = 0; wb_rd = 5'd6; wb_we = 0; #1;
    chk("R4 we low a", fwd_a, 0); chk("R4 we low b", fwd_b, 0);
    idle(); id_rs = 5'd0; id_rs_use = 1; ex_rd = 5'd0; ex_we = 1; ex_load = 1; #1;
    chk_stall("R4 r0 load", 0);
    idle(); id_rs = 5'd2; id_rs_use = 1; ex_rd = 5'd2; ex_we = 0; ex_load = 1; #1;
    chk_stall("R4 load no we", 0);
    idle(); id_branch = 1; id_rs = 5'd4; mem_rd = 5'd4; mem_we = 0; #1;
    chk("R4 idfwd we low", id_fwd_a, 0);
  endtask

  task automatic t_load_use_r5();
    idle(); id_rs = 5'd10; id_rs_use = 1; ex_rd = 5'd10; ex_we = 1; ex_load = 1; #1;
    chk_stall("R5 rs", 1);
    idle(); id_rt = 5'd11; id_rt_use = 1; ex_rd = 5'd11; ex_we = 1; ex_load = 1; #1;
    chk_stall("R5 rt", 1);
    idle(); id_rs = 5'd10; id_rs_use = 1; ex_rd = 5'd10; ex_we = 1; ex_load = 0; #1;
    chk_stall("R5 alu no stall", 0);
  endtask

  task automatic t_unused_r6();
    idle(); id_rt = 5'd13; id_rt_use = 0; id_rs = 5'd1; id_rs_use = 1;
    ex_rd = 5'd13; ex_we = 1; ex_load = 1; #1;
    chk_stall("R6 unused rt", 0);
  endtask

  task automatic t_branch_ex_r7();
    idle(); id_branch = 1; id_br_taken = 1; id_rs = 5'd14; ex_rd = 5'd14; ex_we = 1; #1;
    chk_stall("R7 alu in ex", 1);
    idle(); id_branch = 1; id_rt = 5'd15; ex_rd = 5'd15; ex_we = 1; ex_load = 1; #1;
    chk_stall("R7 load in ex", 1);
  endtask

  task automatic t_branch_mem_r8();
    idle(); id_branch = 1; id_rs = 5'd16; mem_rd = 5'd16; mem_we = 1; mem_load = 1; #1;
    chk_stall("R8 load in mem", 1);
    chk("R8 no idfwd on load", id_fwd_a, 0);
    idle(); id_branch = 1; id_rs = 5'd16; id_rt = 5'd17; mem_rd = 5'd17; mem_we = 1; #1;
    chk_stall("R8 alu in mem", 0);
    chk("R8 idfwd b", id_fwd_b, 1); chk("R8 idfwd a", id_fwd_a, 0);
  endtask

  task automatic t_flush_r9();
    idle(); id_branch = 1; id_br_taken = 1; id_rs = 5'd1; id_rt = 5'd2; #1;
    chk("R9 taken flush", ifid_flush, 1);
    idle(); id_branch = 1; id_br_taken = 0; #1;
    chk("R9 not taken", ifid_flush, 0);
    idle(); id_branch = 1; id_br_taken = 1; id_rs = 5'd20; ex_rd = 5'd20; ex_we = 1; #1;
    chk("R9 stalled no flush", ifid_flush, 0);
  endtask

  task automatic t_wb_decode_r10();
    idle(); id_branch = 1; id_rs = 5'd21; id_rs_use = 1; wb_rd = 5'd21; wb_we = 1; #1;
    chk("R10 no idfwd", id_fwd_a, 0);
    chk_stall("R10", 0);
  endtask

  initial begin
    t_reset_state();
    t_mem_fwd_r1();
    t_wb_fwd_r2();
    t_priority_r3();
    t_zero_disabled_r4();
    t_load_use_r5();
    t_unused_r6();
    t_branch_ex_r7();
    t_branch_mem_r8();
    t_flush_r9();
    t_wb_decode_r10();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule